// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is an N-stage register that can act in four ways, chosen by a two-bit mode input. It can work as a plain parallel register, as one link of a serial scan chain, as a pseudorandom pattern source that runs by itself, or as a multiple-input signature register that folds a whole parallel word into its state on every clock. A test controller places one of these registers in front of a circuit under test and another behind it. The first feeds the circuit with patterns and the second compacts its responses. Between test phases, the controller shifts seeds in and signatures out through the scan pins.

Both the pattern and signature modes use the same feedback: one step multiplies the state, read as a polynomial over GF(2), by x modulo the feedback polynomial. The polynomial is the parameter `POLY`. Its bit i holds the coefficient of x^i, bit 0 must be 1, and the x^WIDTH term is implied. The default is primitive for widths 3, 4, 5, 8, 16 and 32 (for example 1 + x + x^3 for width 3 and 1 + x^2 + x^3 + x^4 + x^8 for width 8). Every stage updates on every rising clock edge and there is no hold state, so the data pins are plain per-cycle signals with no valid/ready handshake and no back-pressure.

Top module: `selftest_reg`

## Requirements
- R1: While `rst_n` is low, all stages of `par_q` are 0, and this happens without waiting for a clock edge.
- R2: Mode `2'b00` (scan): at each clock edge stage 0 takes `scan_in` and stage i takes the old stage i-1.
- R3: `scan_out` equals stage WIDTH-1 of `par_q` in every mode and cycle.
- R4: In scan mode, WIDTH clocks with `scan_in` held at 0 clear every stage, whatever the prior contents.
- R5: Mode `2'b10` (normal): at each clock edge `par_q` takes `par_d`.
- R6: Mode `2'b01` (pattern source): the next state is stage 0 = old stage WIDTH-1, and stage i = old stage i-1 XOR (POLY[i] AND old stage WIDTH-1). `par_d` and `scan_in` have no effect.
- R7: In pattern-source mode, a state of all zeros stays all zeros.
- R8: In pattern-source mode with a primitive `POLY` and a non-zero seed, the state first returns to the seed after exactly 2^WIDTH - 1 clocks, and it visits every non-zero value once on the way.
- R9: Mode `2'b11` (signature): the next state is the R6 step of the old state XOR `par_d`, bit for bit.
- R10: In signature mode, starting from zero, the signature of the bitwise XOR of two input streams equals the XOR of the two streams' separate signatures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode | input | 2 | 00 scan, 01 pattern source, 10 normal, 11 signature |
| par_d | input | WIDTH | Parallel data in (normal and signature modes) |
| scan_in | input | 1 | Serial data into stage 0 |
| par_q | output | WIDTH | Register state |
| scan_out | output | 1 | Last stage, serial data out |

## Verification
The bench loads a seed of one and runs the pattern source for a full period. A wrong tap or wrong shift direction shows up as a short cycle or a repeated state. It loads all zeros and drives random parallel data in pattern mode. A design that leaks `par_d` into that mode would leave the stuck zero state, and so would one that inverts the feedback. It runs three signature streams to check superposition, which fails if the fold is not a pure XOR. It also drives random mode changes from cycle to cycle. These catch a swapped mode encoding and a stage that takes its neighbour in the wrong direction.

// File: rtl/st_pkg.sv
package st_pkg;

  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_PRPG = 2'b01,
    MODE_LOAD = 2'b10,
    MODE_MISR = 2'b11
  } st_mode_e;

  // Feedback coefficients (bit i = x^i, x^w implied) of a primitive polynomial.
  function automatic logic [63:0] default_poly(int w);
    case (w)
      3:       return 64'h3;
      4:       return 64'h3;
      5:       return 64'h5;
      8:       return 64'h1D;
      16:      return 64'h100B;
      32:      return 64'h0040_0007;
      default: return 64'h3;
    endcase
  endfunction

endpackage

// File: rtl/st_galois_step.sv
module st_galois_step #(
  parameter int unsigned           WIDTH = 8,
  parameter logic [WIDTH-1:0]      POLY  = 8'h1D
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  localparam int unsigned MSB = WIDTH - 1;

  // Multiply by x modulo the feedback polynomial (internal-XOR form).
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = cur[MSB];
    end else begin : g_body
      assign nxt[i] = cur[i-1] ^ (POLY[i] & cur[MSB]);
    end
  end

endmodule

// File: rtl/st_stage_sel.sv
module st_stage_sel #(
  parameter int unsigned WIDTH = 8
) (
  input  st_pkg::st_mode_e  mode,
  input  logic [WIDTH-1:0]  shift_src,
  input  logic [WIDTH-1:0]  galois,
  input  logic [WIDTH-1:0]  par_d,
  output logic [WIDTH-1:0]  nxt
);

  import st_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        MODE_SCAN: nxt[i] = shift_src[i];
        MODE_PRPG: nxt[i] = galois[i];
        MODE_LOAD: nxt[i] = par_d[i];
        MODE_MISR: nxt[i] = galois[i] ^ par_d[i];
        default:   nxt[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/selftest_reg.sv
module selftest_reg #(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY  = WIDTH'(st_pkg::default_poly(WIDTH))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_d,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_q,
  output logic             scan_out
);

  import st_pkg::*;

  localparam int unsigned MSB = WIDTH - 1;

  st_mode_e         mode_e;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] shift_src;
  logic [WIDTH-1:0] galois;
  logic [WIDTH-1:0] state_d;

  assign mode_e    = st_mode_e'(mode);
  assign shift_src = {state_q[MSB-1:0], scan_in};

  st_galois_step #(.WIDTH(WIDTH), .POLY(POLY)) u_step (
    .cur (state_q),
    .nxt (galois)
  );

  st_stage_sel #(.WIDTH(WIDTH)) u_sel (
    .mode      (mode_e),
    .shift_src (shift_src),
    .galois    (galois),
    .par_d     (par_d),
    .nxt       (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign par_q    = state_q;
  assign scan_out = state_q[MSB];

  // R1: cleared whenever reset is held
  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (par_q == '0);
  end

  // R2: scan mode shifts one place toward the last stage
  a_r2_scan_shift: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> par_q == {$past(par_q[MSB-1:0]), $past(scan_in)});

  // R3: serial output follows the last stage on the next cycle as well
  a_r3_scan_out_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> scan_out == $past(par_q[MSB-1]));

  // R5: normal mode captures parallel input
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> par_q == $past(par_d));

  // R7: pattern source locks at zero
  a_r7_zero_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && par_q == '0) |=> par_q == '0);

  // R8: pattern source never reaches zero from a non-zero state
  a_r8_nonzero_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && par_q != '0) |=> par_q != '0);

  // R6: pattern source rotates last stage into stage 0
  a_r6_head_feed: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> par_q[0] == $past(par_q[MSB]));

endmodule

// File: tb/selftest_reg_tb.sv
module selftest_reg_tb;

  localparam int W = 8;
  localparam logic [W-1:0] PB = 8'h1D;
  localparam int PERIOD = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b10;
  logic [W-1:0] par_d = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] par_q;
  logic         scan_out;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q;

  always #10 clk = ~clk;

  selftest_reg u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_d(par_d),
    .scan_in(scan_in), .par_q(par_q), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] mul_x(logic [W-1:0] q);
    return {q[W-2:0], 1'b0} ^ (q[W-1] ? PB : '0);
  endfunction

  function automatic logic [W-1:0] model(logic [1:0] m, logic [W-1:0] q,
                                         logic [W-1:0] d, logic s);
    case (m)
      2'b00:   return {q[W-2:0], s};
      2'b01:   return mul_x(q);
      2'b10:   return d;
      default: return mul_x(q) ^ d;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, clock once, compare at the following negedge.
  task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic s, input string req);
    mode = m; par_d = d; scan_in = s;
    exp_q = model(m, exp_q, d, s);
    @(posedge clk);
    @(negedge clk);
    check(req, par_q, exp_q);
    check("R3", {7'b0, scan_out}, {7'b0, exp_q[W-1]});
  endtask

  task automatic finish_up();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic misr_run(input logic [W-1:0] s [20], output logic [W-1:0] sig);
    step(2'b10, '0, 1'b0, "R5");
    for (int k = 0; k < 20; k++) step(2'b11, s[k], 1'b0, "R9");
    sig = par_q;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [W-1:0] sa [20];
    logic [W-1:0] sb [20];
    logic [W-1:0] sc [20];
    logic [W-1:0] sig_a, sig_b, sig_c;
    logic [PERIOD:0] seen;
    int distinct, first_ret;
    void'($urandom(32'd2024));

    // R1: reset state
    #5;
    check("R1", par_q, '0);
    check("R3", {7'b0, scan_out}, 8'h00);
    @(negedge clk);
    @(negedge clk);
    check("R1", par_q, '0);
    rst_n = 1'b1;
    exp_q = '0;

    // R2: random scan
    for (int k = 0; k < 40; k++) step(2'b00, W'($urandom), 1'($urandom), "R2");

    // R4: ones then scan zeros
    step(2'b10, '1, 1'b1, "R5");
    for (int k = 0; k < W; k++) step(2'b00, '1, 1'b0, "R4");
    check("R4", par_q, '0);

    // R5: random loads
    for (int k = 0; k < 30; k++) step(2'b10, W'($urandom), 1'($urandom), "R5");

    // R6: pattern source with noisy par_d and scan_in
    step(2'b10, 8'hA5, 1'b0, "R5");
    for (int k = 0; k < 40; k++) step(2'b01, W'($urandom), 1'($urandom), "R6");

    // R7: zero lock with random parallel data
    step(2'b10, '0, 1'b0, "R5");
    for (int k = 0; k < 12; k++) step(2'b01, W'($urandom), 1'($urandom), "R7");
    check("R7", par_q, '0);

    // R8: full period from seed 1
    step(2'b10, 8'h01, 1'b0, "R5");
    seen = '0; distinct = 0; first_ret = 0;
    for (int k = 1; k <= PERIOD; k++) begin
      mode = 2'b01; par_d = W'($urandom);
      @(posedge clk);
      @(negedge clk);
      if (par_q != '0 && !seen[par_q]) begin seen[par_q] = 1'b1; distinct++; end
      if (par_q == 8'h01 && first_ret == 0) first_ret = k;
    end
    exp_q = par_q;
    check("R8", W'(first_ret), W'(PERIOD));
    check("R8", W'(distinct), W'(PERIOD));
    check("R8", par_q, 8'h01);

    // R9: random signature
    step(2'b10, W'($urandom), 1'b0, "R5");
    for (int k = 0; k < 50; k++) step(2'b11, W'($urandom), 1'($urandom), "R9");

    // R10: superposition
    for (int k = 0; k < 20; k++) begin
      sa[k] = W'($urandom); sb[k] = W'($urandom); sc[k] = sa[k] ^ sb[k];
    end
    misr_run(sa, sig_a);
    misr_run(sb, sig_b);
    misr_run(sc, sig_c);
    check("R10", sig_c, sig_a ^ sig_b);

    // Mixed modes, all requirements against the model
    for (int k = 0; k < 200; k++)
      step(2'($urandom), W'($urandom), 1'($urandom), "R2_R5_R6_R9_mixed");

    finish_up();
  end

endmodule